// File: doc/BRIEF.md
# Debounced Level Interrupt Controller

This block gathers sixteen asynchronous external input lines and turns them into one level-sensitive interrupt. Each line passes through a two-flop synchroniser and then a debounce filter that only accepts a new level after the synchronised input has stayed at that value for a programmed number of millisecond ticks. The tick is a single-cycle enable strobe that comes from outside the block. Software starts or restarts a channel's filter by writing to a trigger register. Until a channel has been triggered at least once after reset, its filtered level stays at 0 and it cannot raise status.

Each channel has its own polarity bit that selects active-high or active-low detection. There are no edge modes. When a channel's filtered level matches its active polarity, its raw status bit is set. The raw status is ANDed with a per-channel enable to give the masked status, and the interrupt output is the OR of all masked status bits. Software clears a status bit by writing 1 to it in the clear register. If the level is still active, the status sets again at once. The block is reached through a simple register port with single-cycle write and read strobes, an 8-bit byte address and 32-bit data. Read data is combinational while the read strobe is high.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every readable register reads 0, every filter holds level 0, every channel is disarmed and `irq` is low.
- R2: Register offsets are: input level 0x00, level-read enable 0x04, polarity 0x14, interrupt enable 0x18, raw status 0x1C, masked status 0x20, clear 0x24, trigger 0x28. Bit n is channel n in each of these registers. Bits 31:16 always read 0. Raw status, masked status and the input level register are read-only.
- R3: Bit n of the input level register returns channel n's filtered level only when bit n of the level-read enable register is 1. Otherwise that bit reads 0.
- R4: Polarity bit 1 makes level 1 active and polarity bit 0 makes level 0 active. Raw status bit n is set on every cycle in which armed channel n has its filtered level equal to its active level.
- R5: Masked status equals raw status AND interrupt enable. `irq` is high exactly while the masked status is nonzero.
- R6: Writing 1 to bit n of the clear register clears raw status bit n. Writing 0 has no effect. If the level is still active in that cycle, the set wins and the bit stays 1. The clear register reads 0.
- R7: Writing 1 to bit n of the trigger register produces a one-cycle pulse that arms channel n and restarts its debounce count. The trigger register reads 0 afterwards. A channel that has never been armed keeps level 0 and never sets raw status.
- R8: Bits 11:0 of the control word at 0x40+4n give channel n's debounce length D in ticks. With D>0, the filtered level takes the new synchronised value on the D-th tick counted while the input differs from the level. With D=0, the level follows the synchronised input on the next cycle.
- R9: Each control word stores all 32 bits written and reads them back unchanged, including bits 31:12.
- R10: A trigger pulse during a debounce count discards the ticks already counted, so D fresh ticks are needed after the pulse.
- R11: The channels are input-only. A write to the input level register at 0x00 does not change any channel level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle millisecond enable strobe |
| pins_in | input | 16 | Asynchronous external input lines |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read strobe; rdata is 0 when low |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| irq | output | 1 | Combined level interrupt |

## Verification
Two functions can act on the same cycle: a software clear of a raw status bit and the hardware setting that bit because the filtered level is still active. The bench provokes this by holding a channel's pin at its active level and writing 1 to that bit of the clear register. It then reads raw status and expects the bit to still be 1. It next drops the pin to its inactive level and clears again, and expects the bit to read 0. The trigger pulse and a millisecond tick are also placed close together in the middle of a count, and the filtered level is read just before and just after the tick that should complete the restarted count.

// File: rtl/lic_pkg.sv
// Package: shared constants for the level interrupt controller.
// Assumes a byte-addressed register port with 32-bit words.
package lic_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_LEVEL  = 8'h00;
    localparam logic [ADDR_W-1:0] A_RDEN   = 8'h04;
    localparam logic [ADDR_W-1:0] A_POL    = 8'h14;
    localparam logic [ADDR_W-1:0] A_IEN    = 8'h18;
    localparam logic [ADDR_W-1:0] A_RAW    = 8'h1C;
    localparam logic [ADDR_W-1:0] A_MASKED = 8'h20;
    localparam logic [ADDR_W-1:0] A_CLR    = 8'h24;
    localparam logic [ADDR_W-1:0] A_TRIG   = 8'h28;
    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h40;
endpackage

// File: rtl/lic_sync.sv
// Module: two-flop synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherency is implied.
module lic_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Purpose: two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/lic_filter.sv
// Module: per-channel debounce filter with software arming.
// Assumes din_i is already synchronous. The level only moves once armed;
// restart_i arms the filter and discards any partial count.
module lic_filter #(
    parameter int DBT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic             din_i,
    input  logic [DBT_W-1:0] dbt_i,
    output logic             armed_o,
    output logic             level_o
);
    logic             armed_q;
    logic             level_q;
    logic [DBT_W-1:0] cnt_q;
    logic [DBT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + {{DBT_W{1'b0}}, 1'b1};

    // Purpose: arm on restart, count ticks while input differs, update level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            level_q <= 1'b0;
            cnt_q   <= '0;
        end else if (restart_i) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
        end else if (armed_q) begin
            if (din_i == level_q) begin
                cnt_q <= '0;
            end else if (dbt_i == '0) begin
                level_q <= din_i;
                cnt_q   <= '0;
            end else if (tick_i) begin
                if (cnt_inc >= {1'b0, dbt_i}) begin
                    level_q <= din_i;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_inc[DBT_W-1:0];
                end
            end
        end
    end

    assign armed_o = armed_q;
    assign level_o = level_q;

    // R8: with a nonzero length, the level never moves on a cycle without a tick.
    p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && dbt_i != '0) |=> $stable(level_q));

    // R7: a filter that was never armed holds level 0.
    p_unarmed_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> (level_q == 1'b0));
endmodule

// File: rtl/lvl_irq_ctrl.sv
// Module: sixteen-channel debounced level interrupt controller (top).
// Assumes ms_tick is a one-cycle strobe in the clk domain and that the
// register port issues single-cycle strobes. Read data is combinational.
module lvl_irq_ctrl
    import lic_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int DBT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic [NCH-1:0]    pins_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int PAD_W = DATA_W - NCH;
    localparam logic [ADDR_W-3:0] CH_LIM = (ADDR_W-2)'(NCH);

    logic [NCH-1:0]    rden_q, pol_q, ien_q, raw_q, trig_q;
    logic [DATA_W-1:0] ctrl_q [NCH];
    logic [NCH-1:0]    sync_s, armed_s, level_s, active_s, clr_s, masked_s;
    logic [ADDR_W-1:0] ctrl_off;
    logic              ctrl_hit;
    logic [IDX_W-1:0]  ctrl_idx;
    logic              wr_trig;

    // Purpose: decode the per-channel control word window.
    always_comb begin
        ctrl_off = addr - A_CTRL;
        ctrl_hit = (addr >= A_CTRL) && (ctrl_off[1:0] == 2'b00)
                   && (ctrl_off[ADDR_W-1:2] < CH_LIM);
        ctrl_idx = ctrl_off[IDX_W+1:2];
    end

    assign wr_trig = wr_en && (addr == A_TRIG);
    assign clr_s   = (wr_en && addr == A_CLR) ? wdata[NCH-1:0] : '0;

    lic_sync #(.W(NCH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_in),
        .sync_o  (sync_s)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        lic_filter #(.DBT_W(DBT_W)) u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (ms_tick),
            .restart_i (trig_q[i]),
            .din_i     (sync_s[i]),
            .dbt_i     (ctrl_q[i][DBT_W-1:0]),
            .armed_o   (armed_s[i]),
            .level_o   (level_s[i])
        );

        // Purpose: hold the full 32-bit control word of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q[i] <= '0;
            end else if (wr_en && ctrl_hit && ctrl_idx == IDX_W'(i)) begin
                ctrl_q[i] <= wdata;
            end
        end
    end

    assign active_s = armed_s & ~(level_s ^ pol_q);
    assign masked_s = raw_q & ien_q;
    assign irq      = |masked_s;

    // Purpose: software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rden_q <= '0;
            pol_q  <= '0;
            ien_q  <= '0;
        end else if (wr_en) begin
            if (addr == A_RDEN) rden_q <= wdata[NCH-1:0];
            if (addr == A_POL)  pol_q  <= wdata[NCH-1:0];
            if (addr == A_IEN)  ien_q  <= wdata[NCH-1:0];
        end
    end

    // Purpose: one-cycle trigger pulse from a trigger register write.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= '0;
        else        trig_q <= wr_trig ? wdata[NCH-1:0] : '0;
    end

    // Purpose: raw status, set by an active level and winning over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_s) | active_s;
    end

    // Purpose: combinational read multiplexer, zero when not reading.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (ctrl_hit) begin
                rdata = ctrl_q[ctrl_idx];
            end else begin
                case (addr)
                    A_LEVEL:  rdata = {{PAD_W{1'b0}}, level_s & rden_q};
                    A_RDEN:   rdata = {{PAD_W{1'b0}}, rden_q};
                    A_POL:    rdata = {{PAD_W{1'b0}}, pol_q};
                    A_IEN:    rdata = {{PAD_W{1'b0}}, ien_q};
                    A_RAW:    rdata = {{PAD_W{1'b0}}, raw_q};
                    A_MASKED: rdata = {{PAD_W{1'b0}}, masked_s};
                    A_TRIG:   rdata = {{PAD_W{1'b0}}, trig_q};
                    default:  rdata = '0;
                endcase
            end
        end
    end

    // R4: an active armed channel has raw status set on the next cycle.
    p_raw_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & $past(active_s)) == $past(active_s)));

    // R6: a clear on an inactive channel leaves the bit at 0.
    p_clear_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & $past(clr_s & ~active_s)) == '0));

    // R7: the trigger pulse lasts one cycle unless written again.
    p_trig_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_trig |=> (trig_q == '0));
endmodule

// File: tb/tb_lvl_irq_ctrl.sv
module tb_lvl_irq_ctrl;
    localparam int CLK_P = 10;
    localparam int NV    = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b0;
    logic [15:0] pins_in = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Register walk table: {address, write value, expected read}.
    localparam logic [71:0] VEC [NV] = '{
        {8'h04, 32'hFFFF_FFFF, 32'h0000_FFFF},
        {8'h14, 32'h1234_A5A5, 32'h0000_A5A5},
        {8'h18, 32'hFFFF_0000, 32'h0000_0000},
        {8'h40, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {8'h7C, 32'h1234_5FFF, 32'h1234_5FFF},
        {8'h24, 32'h0000_FFFF, 32'h0000_0000},
        {8'h28, 32'h0000_0000, 32'h0000_0000},
        {8'h00, 32'h0000_FFFF, 32'h0000_0000},
        {8'h1C, 32'h0000_FFFF, 32'h0000_0000},
        {8'h20, 32'h0000_FFFF, 32'h0000_0000}
    };

    lvl_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pins_in(pins_in),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        rd_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        for (int a = 0; a < 'h80; a += 4) begin
            rd(8'(a), v);
            if (v !== 32'h0) chk("R1 reset readback", v, 32'h0);
        end
        chk("R1 reset irq", {31'h0, irq}, 32'h0);

        // R2 R9 R7 R11: register walk
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], v);
            chk("R2/R9 register walk", v, VEC[i][31:0]);
        end
        wr(8'h04, 0); wr(8'h14, 0); wr(8'h18, 0); wr(8'h40, 0); wr(8'h7C, 0);

        // R4 active-high, R6 set wins over clear
        wr(8'h14, 32'h1);
        pins_in[0] = 1'b1;
        wr(8'h28, 32'h1); idle(6);
        rd(8'h1C, v); chk("R4 active-high sets raw", v & 32'h1, 32'h1);
        wr(8'h24, 32'h1); idle(2);
        rd(8'h1C, v); chk("R6 set wins over clear", v & 32'h1, 32'h1);
        pins_in[0] = 1'b0; idle(6);
        wr(8'h24, 32'h1); idle(2);
        rd(8'h1C, v); chk("R6 clear after inactive", v & 32'h1, 32'h0);

        // R4 active-low, R5 masking and irq
        wr(8'h28, 32'h2); idle(6);
        rd(8'h1C, v); chk("R4 active-low sets raw", v & 32'h2, 32'h2);
        chk("R5 irq low while disabled", {31'h0, irq}, 32'h0);
        wr(8'h18, 32'h2); idle(1);
        chk("R5 irq high when enabled", {31'h0, irq}, 32'h1);
        rd(8'h20, v); chk("R5 masked status", v, 32'h2);
        pins_in[1] = 1'b1; idle(6);
        wr(8'h24, 32'h0); idle(2);
        rd(8'h1C, v); chk("R6 zero write no effect", v & 32'h2, 32'h2);
        wr(8'h24, 32'h2); idle(2);
        rd(8'h1C, v); chk("R6 clear inactive ch1", v & 32'h2, 32'h0);
        chk("R5 irq low after clear", {31'h0, irq}, 32'h0);

        // R3 level-read enable
        rd(8'h00, v); chk("R3 gated level reads 0", v, 32'h0);
        wr(8'h04, 32'h2);
        rd(8'h00, v); chk("R3 enabled level", v, 32'h2);

        // R7 unarmed channel never sets
        wr(8'h14, 32'h11);
        pins_in[4] = 1'b1; idle(6);
        rd(8'h1C, v); chk("R7 unarmed no raw", v & 32'h10, 32'h0);
        wr(8'h04, 32'h10);
        rd(8'h00, v); chk("R7 unarmed level 0", v, 32'h0);
        wr(8'h28, 32'h10); idle(6);
        rd(8'h1C, v); chk("R7 armed sets raw", v & 32'h10, 32'h10);
        rd(8'h28, v); chk("R7 trigger reads 0", v, 32'h0);

        // R8 debounce of 3 ticks on ch2
        wr(8'h48, 32'h3); wr(8'h14, 32'h15); wr(8'h04, 32'h4);
        wr(8'h28, 32'h4); idle(3);
        pins_in[2] = 1'b1; idle(5);
        tick(); tick();
        rd(8'h00, v); chk("R8 level held before D ticks", v, 32'h0);
        tick();
        rd(8'h00, v); chk("R8 level after D ticks", v, 32'h4);

        // R10 restart mid-count on ch3 with D=2
        wr(8'h4C, 32'h2); wr(8'h14, 32'h1D); wr(8'h04, 32'h8);
        wr(8'h28, 32'h8); idle(3);
        pins_in[3] = 1'b1; idle(5);
        tick();
        wr(8'h28, 32'h8); idle(3);
        tick();
        rd(8'h00, v); chk("R10 count restarted", v, 32'h0);
        tick();
        rd(8'h00, v); chk("R10 level after fresh count", v, 32'h8);

        // R11 write to level register has no effect
        wr(8'h00, 32'hFFFF);
        wr(8'h04, 32'hFFFF);
        rd(8'h00, v); chk("R11 levels unchanged", v, 32'h1E);

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        idle(2); rst_n = 1'b1; idle(1);
        rd(8'h1C, v); chk("R1 raw after reset", v, 32'h0);
        rd(8'h04, v); chk("R1 enable after reset", v, 32'h0);
        rd(8'h48, v); chk("R1 control after reset", v, 32'h0);
        chk("R1 irq after reset", {31'h0, irq}, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule